// File: doc/BRIEF.md
# Dual-Channel Segmented DAC Switch Decoder

This block is the digital front end of a two-channel, 8-bit current-steering converter. The channels are called I and Q, and they share one clock, one reset and one sleep input. Each channel takes an offset-binary word on a rising clock edge and holds it in a capture register. It then splits the word into two fields. The upper five bits become a 31-bit thermometer code, with one bit for each equal-weight current segment. The lower three bits pass straight through as binary-weighted switch controls. The decoded controls are registered a second time. A word therefore reaches the switch outputs on the second rising edge after it is presented.

Every switch is driven as a complementary pair, so its current goes either to the A output or to the B output. The weight on A equals the input code, and the weight on B equals 255 minus the code. While sleep is high, every A and B control is forced low and both pipeline stages hold their contents. When the block wakes, it resumes from the word it held.

Top module: `dual_seg_dac_front`

## Requirements
- R1: While rst_ni is low, both pipeline stages hold code 0x00. When sleep is low, every A-side control is then 0 and every B-side control is 1.
- R2: A word present at rising edge k appears on the switch outputs just after rising edge k+1. It stays there until the edge that loads the next word.
- R3: For upper field N = code[7:3], segment outputs a[0] to a[N-1] are 1 and a[N] to a[30] are 0, so the thermometer is always contiguous from bit 0.
- R4: Binary output bit j (j = 0 to 2) on the A side equals code bit j and carries weight 2^j. Each segment carries weight 8.
- R5: While sleep is low, every B-side control is the inverse of its A-side partner.
- R6: While sleep is low, the weight on A (8 x active segments + binary value) equals the code. The A weight plus the B weight equals 255.
- R7: Code 0xFF drives all A controls to 1 and all B controls to 0. Code 0x00 does the reverse. Code 0x80 puts 16 segments on A and 15 segments plus all three binary bits on B, which gives weights of 128 and 127.
- R8: While sleep is high, every A-side and B-side control of both channels is 0, whatever the data inputs do.
- R9: While sleep is high, both pipeline stages keep their contents. Right after wake-up the outputs show the word held before sleep. That word stays for one more edge, and the first word captured after wake-up appears after the following edge.
- R10: The I and Q channels behave identically and independently. Each output depends only on its own data input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock, rising edge active |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sleep_i | input | 1 | Low-power mode; forces all switch controls low |
| i_word_i | input | 8 | I-channel offset-binary data word |
| q_word_i | input | 8 | Q-channel offset-binary data word |
| i_seg_a_o | output | 31 | I thermometer segment controls, A side |
| i_seg_b_o | output | 31 | I thermometer segment controls, B side |
| i_bin_a_o | output | 3 | I binary LSB switch controls, A side |
| i_bin_b_o | output | 3 | I binary LSB switch controls, B side |
| q_seg_a_o | output | 31 | Q thermometer segment controls, A side |
| q_seg_b_o | output | 31 | Q thermometer segment controls, B side |
| q_bin_a_o | output | 3 | Q binary LSB switch controls, A side |
| q_bin_b_o | output | 3 | Q binary LSB switch controls, B side |

## Verification
A data word is due at the switch outputs two rising edges after it is driven. The bench therefore drives at a falling edge and compares outputs two falling edges later. The streaming test compares each output against the word driven two falling edges earlier. Sleep gating acts without a register, so the bench checks it one time step after the sleep change, within the same cycle. Wake-up is checked three times: at once, after one edge (the held word is still due) and after a second edge (the new word is due).

// File: rtl/dac_seg_pkg.sv
package dac_seg_pkg;
  localparam int unsigned WORD_W_DEF = 8;
  localparam int unsigned LSB_W_DEF  = 3;
  localparam int unsigned NUM_CH     = 2;
endpackage

// File: rtl/seg_thermo_dec.sv
module seg_thermo_dec #(
  parameter int unsigned IN_W  = 5,
  parameter int unsigned OUT_N = (1 << IN_W) - 1
) (
  input  logic [IN_W-1:0]  code_i,
  output logic [OUT_N-1:0] therm_o
);
  for (genvar g = 0; g < OUT_N; g++) begin : g_seg
    assign therm_o[g] = (32'(code_i) > g);
  end
endmodule

// File: rtl/seg_pair_drive.sv
module seg_pair_drive #(
  parameter int unsigned N = 31
) (
  input  logic         sleep_i,
  input  logic [N-1:0] on_i,
  output logic [N-1:0] a_o,
  output logic [N-1:0] b_o
);
  always_comb begin
    a_o = sleep_i ? '0 :  on_i;
    b_o = sleep_i ? '0 : ~on_i;
  end
endmodule

// File: rtl/seg_channel.sv
module seg_channel #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned LSB_W  = 3,
  localparam int unsigned MSB_W = WORD_W - LSB_W,
  localparam int unsigned SEG_N = (1 << MSB_W) - 1,
  localparam int unsigned FULL  = (1 << WORD_W) - 1,
  localparam int unsigned SEG_WT = 1 << LSB_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [SEG_N-1:0]  seg_a_o,
  output logic [SEG_N-1:0]  seg_b_o,
  output logic [LSB_W-1:0]  bin_a_o,
  output logic [LSB_W-1:0]  bin_b_o
);
  logic [WORD_W-1:0] word_q;
  logic [SEG_N-1:0]  therm_d, seg_q;
  logic [LSB_W-1:0]  bin_q;

  // capture stage; frozen in sleep
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       word_q <= '0;
    else if (!sleep_i) word_q <= word_i;
  end

  seg_thermo_dec #(.IN_W(MSB_W), .OUT_N(SEG_N)) u_dec (
    .code_i  (word_q[WORD_W-1:LSB_W]),
    .therm_o (therm_d)
  );

  // switch-drive stage
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seg_q <= '0;
      bin_q <= '0;
    end else if (!sleep_i) begin
      seg_q <= therm_d;
      bin_q <= word_q[LSB_W-1:0];
    end
  end

  seg_pair_drive #(.N(SEG_N)) u_seg_drv (
    .sleep_i (sleep_i),
    .on_i    (seg_q),
    .a_o     (seg_a_o),
    .b_o     (seg_b_o)
  );

  seg_pair_drive #(.N(LSB_W)) u_bin_drv (
    .sleep_i (sleep_i),
    .on_i    (bin_q),
    .a_o     (bin_a_o),
    .b_o     (bin_b_o)
  );

  p_latency_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |=> ($countones(seg_q) == int'($past(word_q[WORD_W-1:LSB_W]))
                  && bin_q == $past(word_q[LSB_W-1:0])));

  p_thermo_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_q & (seg_q + SEG_N'(1))) == '0);

  p_complement_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> (seg_b_o == ~seg_a_o && bin_b_o == ~bin_a_o));

  p_weight_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sleep_i |-> ($countones(seg_a_o) * SEG_WT + int'(bin_a_o)
                  + $countones(seg_b_o) * SEG_WT + int'(bin_b_o) == FULL));

  p_sleep_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> (seg_a_o == '0 && seg_b_o == '0 && bin_a_o == '0 && bin_b_o == '0));

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> ($stable(word_q) && $stable(seg_q) && $stable(bin_q)));
endmodule

// File: rtl/dual_seg_dac_front.sv
module dual_seg_dac_front #(
  parameter int unsigned WORD_W = dac_seg_pkg::WORD_W_DEF,
  parameter int unsigned LSB_W  = dac_seg_pkg::LSB_W_DEF,
  localparam int unsigned SEG_N = (1 << (WORD_W - LSB_W)) - 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_i,
  input  logic [WORD_W-1:0] i_word_i,
  input  logic [WORD_W-1:0] q_word_i,
  output logic [SEG_N-1:0]  i_seg_a_o,
  output logic [SEG_N-1:0]  i_seg_b_o,
  output logic [LSB_W-1:0]  i_bin_a_o,
  output logic [LSB_W-1:0]  i_bin_b_o,
  output logic [SEG_N-1:0]  q_seg_a_o,
  output logic [SEG_N-1:0]  q_seg_b_o,
  output logic [LSB_W-1:0]  q_bin_a_o,
  output logic [LSB_W-1:0]  q_bin_b_o
);
  localparam int unsigned NCH = dac_seg_pkg::NUM_CH;

  logic [NCH-1:0][WORD_W-1:0] word;
  logic [NCH-1:0][SEG_N-1:0]  seg_a, seg_b;
  logic [NCH-1:0][LSB_W-1:0]  bin_a, bin_b;

  assign word[0] = i_word_i;
  assign word[1] = q_word_i;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    seg_channel #(.WORD_W(WORD_W), .LSB_W(LSB_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sleep_i (sleep_i),
      .word_i  (word[c]),
      .seg_a_o (seg_a[c]),
      .seg_b_o (seg_b[c]),
      .bin_a_o (bin_a[c]),
      .bin_b_o (bin_b[c])
    );
  end

  assign i_seg_a_o = seg_a[0];
  assign i_seg_b_o = seg_b[0];
  assign i_bin_a_o = bin_a[0];
  assign i_bin_b_o = bin_b[0];
  assign q_seg_a_o = seg_a[1];
  assign q_seg_b_o = seg_b[1];
  assign q_bin_a_o = bin_a[1];
  assign q_bin_b_o = bin_b[1];
endmodule

// File: tb/tb_dual_seg_dac_front.sv
module tb_dual_seg_dac_front;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sleep_i = 1'b0;
  logic [7:0] i_word = 8'h00, q_word = 8'h00;
  logic [30:0] i_seg_a, i_seg_b, q_seg_a, q_seg_b;
  logic [2:0]  i_bin_a, i_bin_b, q_bin_a, q_bin_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  dual_seg_dac_front dut (
    .clk_i(clk), .rst_ni(rst_ni), .sleep_i(sleep_i),
    .i_word_i(i_word), .q_word_i(q_word),
    .i_seg_a_o(i_seg_a), .i_seg_b_o(i_seg_b), .i_bin_a_o(i_bin_a), .i_bin_b_o(i_bin_b),
    .q_seg_a_o(q_seg_a), .q_seg_b_o(q_seg_b), .q_bin_a_o(q_bin_a), .q_bin_b_o(q_bin_b)
  );

  function automatic logic [30:0] exp_seg(input logic [7:0] code);
    logic [30:0] s;
    for (int i = 0; i < 31; i++) s[i] = (int'(code[7:3]) > i);
    return s;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // full check of one channel against a code (awake)
  task automatic chk_ch(input int ch, input logic [7:0] code, input string req);
    logic [30:0] sa, sb; logic [2:0] ba, bb; int wa, wb;
    sa = ch == 0 ? i_seg_a : q_seg_a; sb = ch == 0 ? i_seg_b : q_seg_b;
    ba = ch == 0 ? i_bin_a : q_bin_a; bb = ch == 0 ? i_bin_b : q_bin_b;
    wa = $countones(sa) * 8 + int'(ba);
    wb = $countones(sb) * 8 + int'(bb);
    chk(sa == exp_seg(code), {req, " R3 seg_a"}, 64'(sa), 64'(exp_seg(code)));
    chk(ba == code[2:0], {req, " R4 bin_a"}, 64'(ba), 64'(code[2:0]));
    chk(sb == ~sa && bb == ~ba, {req, " R5 complement"}, {sb, 1'b0, bb}, {~sa, 1'b0, ~ba});
    chk(wa == int'(code) && wa + wb == 255, {req, " R6 weight"}, 64'(wa), 64'(code));
  endtask

  task automatic chk_asleep(input string req);
    chk({i_seg_a, i_seg_b, i_bin_a, i_bin_b, q_seg_a, q_seg_b, q_bin_a, q_bin_b} == '0,
        req, 64'($countones({i_seg_a, i_seg_b, i_bin_a, i_bin_b, q_seg_a, q_seg_b, q_bin_a, q_bin_b})), 64'd0);
  endtask

  task automatic settle(input logic [7:0] wi, input logic [7:0] wq);
    @(negedge clk); i_word = wi; q_word = wq;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; i_word = 8'hAA; q_word = 8'h55;
    repeat (3) @(negedge clk);
    chk(i_seg_a == '0 && i_bin_a == '0 && i_seg_b == '1 && i_bin_b == '1, "R1 reset I",
        64'({i_seg_a, i_bin_a}), 64'd0);
    chk(q_seg_a == '0 && q_bin_a == '0 && q_seg_b == '1 && q_bin_b == '1, "R1 reset Q",
        64'({q_seg_a, q_bin_a}), 64'd0);
    rst_ni = 1'b1;
  endtask

  task automatic t_endpoints;
    settle(8'hFF, 8'h00);
    chk(i_seg_a == '1 && i_bin_a == '1 && i_seg_b == '0 && i_bin_b == '0, "R7 0xFF",
        64'({i_seg_b, i_bin_b}), 64'd0);
    chk(q_seg_b == '1 && q_bin_b == '1 && q_seg_a == '0 && q_bin_a == '0, "R7 0x00",
        64'({q_seg_a, q_bin_a}), 64'd0);
    settle(8'h80, 8'h80);
    chk($countones(i_seg_a) == 16 && i_bin_a == 3'd0 && $countones(i_seg_b) == 15 && i_bin_b == 3'd7,
        "R7 0x80 split", 64'($countones(i_seg_a)), 64'd16);
    chk_ch(1, 8'h80, "R7 0x80 Q");
  endtask

  task automatic t_sweep;
    for (int c = 0; c < 256; c++) begin
      settle(8'(c), 8'(~c));
      chk_ch(0, 8'(c), "sweep I R10");
      chk_ch(1, 8'(~c), "sweep Q R10");
    end
  endtask

  task automatic t_latency;
    logic [7:0] wi [24];
    logic [7:0] wq [24];
    for (int k = 0; k < 24; k++) begin
      wi[k] = 8'($urandom); wq[k] = 8'($urandom);
    end
    for (int k = 0; k < 24; k++) begin
      @(negedge clk);
      if (k >= 2) begin
        chk_ch(0, wi[k-2], "R2 stream I");
        chk_ch(1, wq[k-2], "R2 stream Q");
      end
      i_word = wi[k]; q_word = wq[k];
    end
  endtask

  task automatic t_sleep;
    settle(8'h5A, 8'hC3);
    @(negedge clk); sleep_i = 1'b1; #1;
    chk_asleep("R8 sleep entry");
    i_word = 8'h11; q_word = 8'h22;
    repeat (3) @(negedge clk);
    chk_asleep("R8 sleep inputs changed");
    sleep_i = 1'b0; #1;
    chk_ch(0, 8'h5A, "R9 wake held I");
    chk_ch(1, 8'hC3, "R9 wake held Q");
    @(negedge clk);
    chk_ch(0, 8'h5A, "R9 wake +1 edge I");
    @(negedge clk);
    chk_ch(0, 8'h11, "R9 wake +2 edges I");
    chk_ch(1, 8'h22, "R9 wake +2 edges Q");
  endtask

  initial begin
    t_reset();
    t_endpoints();
    t_sweep();
    t_latency();
    t_sleep();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule